// File: doc/BRIEF.md
# Domain and Sub-page Access Checker

This block sits in front of an address translator and decides, for every memory request, whether the running task may perform it. Each request carries a 32-bit virtual address and a read/write flag. The block applies two gates. The first is a per-domain rights field in a control register. The domain is the one that owns the 1 MByte region of the address. The second is a permission for each 1 KByte quarter of the mapped 4 KByte page. A request that passes both gates is translated to a physical address. A request that fails is reported as a fault, together with its cause, its address and its access kind.

Translations live in a small, fully associative table of page entries. Each entry holds a valid bit, a virtual page number, a physical page number, a 4-bit domain and four 2-bit sub-page permissions. Software fills the table and the domain control register through a configuration port. When a table write would give two live owners to one physical sub-page, the block raises a configuration error. It also raises that error when the write would leave two domains in one 1 MByte region. In both cases the write is still committed.

Top module: `sp_perm_checker`

## Requirements
- R1: After reset every table entry is invalid, the domain control register is zero, rsp_valid_o and cfg_err_o are low, and a request then reports a translation fault (code 2).
- R2: The result of a request appears on the response outputs on the clock edge after the edge that samples req_valid_i. rsp_valid_o is high for exactly that one cycle per request.
- R3: The 2-bit field for domain d lies at dcr bits [2d+1:2d]. Only the value 01 grants access. The values 00, 10 and 11 deny it, and a denied request reports a domain fault (code 1).
- R4: The domain of an address comes from the lowest-indexed valid entry whose VPN bits [19:8] equal address bits [31:20]. When no entry covers the region, the domain check is skipped.
- R5: A request for which no valid entry's VPN equals address bits [31:12] reports a translation fault (code 2), unless R3 applies first.
- R6: The sub-page permission is perm bits [2s+1:2s], with s = address bits [11:10]. The codes are 00 = none, 01 = read-only, 11 = read-write, and 10 is reserved and means none. A read needs 01 or 11, and a write needs 11. A request that fails this check reports a permission fault (code 3).
- R7: Fault priority is domain, then translation, then permission. A request whose region is in a denied domain reports code 1 even when its page is not mapped.
- R8: On success the physical address is {PPN, address[11:0]}, the fault code is 0, and the reported fault address and write flag are zero. On a fault the physical address is zero, and the fault address and write flag equal the request's.
- R9: A write of a valid entry asserts cfg_err_o in the cycle after the write when another valid entry has the same PPN and both have a non-none permission on the same sub-page. A write of an invalid entry never flags.
- R10: A write of a valid entry asserts cfg_err_o in the cycle after the write when another valid entry in the same 1 MByte region carries a different domain. The write is still committed.
- R11: When several valid entries match the VPN, the lowest-indexed one supplies the PPN and permissions.
- R12: Table and control register writes apply from the next cycle on. A request in the same cycle as a write sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Access request strobe |
| req_addr_i | input | 32 | Virtual address of the request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| cfg_we_i | input | 1 | Table entry write strobe |
| cfg_idx_i | input | IDX_W (3) | Entry index to write |
| cfg_valid_i | input | 1 | Valid bit of the written entry |
| cfg_vpn_i | input | 20 | Virtual page number |
| cfg_ppn_i | input | PPN_W (20) | Physical page number |
| cfg_dom_i | input | 4 | Domain of the entry |
| cfg_perm_i | input | 8 | Four 2-bit sub-page permissions |
| dcr_we_i | input | 1 | Domain control register write strobe |
| dcr_data_i | input | 32 | New domain control register value |
| cfg_err_o | output | 1 | Configuration rule violated by the last table write |
| rsp_valid_o | output | 1 | Response strobe |
| rsp_paddr_o | output | PPN_W+12 (32) | Translated physical address |
| rsp_fault_o | output | 2 | Fault kind: 0 none, 1 domain, 2 translation, 3 permission |
| rsp_fault_addr_o | output | 32 | Faulting virtual address |
| rsp_fault_write_o | output | 1 | Access kind of the faulting request |

## Verification
A corrupted table entry only shows when a request touches it. It then appears in the response cycle as a wrong physical address or a wrong fault code, or, through the alias and region rules, as a wrong cfg_err_o on a later write. A wrong domain control field shows in the response to the first request aimed at a mapped region of that domain. Because requests resolve in one cycle, each directed scenario pins the failing state to a single request. Those requests include same-cycle write/request pairs, overlapping entries, and denied domains over unmapped pages.

// File: rtl/pc_pkg.sv
package pc_pkg;
  parameter int unsigned VA_W   = 32;
  parameter int unsigned PPN_W  = 20;
  parameter int unsigned DOM_W  = 4;
  parameter int unsigned N_SUB  = 4;
  localparam int unsigned VPN_W  = VA_W - 12;
  localparam int unsigned N_DOM  = 1 << DOM_W;
  localparam int unsigned PERM_W = 2 * N_SUB;
  localparam int unsigned DCR_W  = 2 * N_DOM;
  localparam int unsigned RGN_W  = VA_W - 20;

  localparam logic [1:0] SP_NONE = 2'b00;
  localparam logic [1:0] SP_RO   = 2'b01;
  localparam logic [1:0] SP_RW   = 2'b11;
  localparam logic [1:0] DCR_CHK = 2'b01;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_DOMAIN = 2'd1,
    FLT_XLATE  = 2'd2,
    FLT_PERM   = 2'd3
  } fault_e;

  typedef struct packed {
    logic              valid;
    logic [VPN_W-1:0]  vpn;
    logic [PPN_W-1:0]  ppn;
    logic [DOM_W-1:0]  dom;
    logic [PERM_W-1:0] perm;
  } entry_t;

  function automatic logic sp_live(input logic [1:0] c);
    return (c == SP_RO) || (c == SP_RW);
  endfunction
endpackage

// File: rtl/pc_map_table.sv
module pc_map_table
  import pc_pkg::*;
#(
  parameter int unsigned ENTRIES = 8,
  localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [IDX_W-1:0]          wr_idx_i,
  input  entry_t                    wr_entry_i,
  input  logic [VA_W-1:0]           lk_addr_i,
  output entry_t [ENTRIES-1:0]      tbl_o,
  output logic                      vpn_hit_o,
  output logic [PPN_W-1:0]          hit_ppn_o,
  output logic [PERM_W-1:0]         hit_perm_o,
  output logic                      rgn_hit_o,
  output logic [DOM_W-1:0]          rgn_dom_o
);
  entry_t [ENTRIES-1:0] tbl_q;
  logic   [ENTRIES-1:0] vpn_match, rgn_match;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    tbl_q[g] <= '0;
      else if (wr_en_i && wr_idx_i == IDX_W'(g))      tbl_q[g] <= wr_entry_i;
    end
    assign vpn_match[g] = tbl_q[g].valid && (tbl_q[g].vpn == lk_addr_i[VA_W-1:12]);
    assign rgn_match[g] = tbl_q[g].valid &&
                          (tbl_q[g].vpn[VPN_W-1:8] == lk_addr_i[VA_W-1:20]);
  end

  // lowest index wins: scan downward so the last assignment is the lowest hit
  always_comb begin
    vpn_hit_o  = 1'b0;
    hit_ppn_o  = '0;
    hit_perm_o = '0;
    rgn_hit_o  = 1'b0;
    rgn_dom_o  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (vpn_match[i]) begin
        vpn_hit_o  = 1'b1;
        hit_ppn_o  = tbl_q[i].ppn;
        hit_perm_o = tbl_q[i].perm;
      end
      if (rgn_match[i]) begin
        rgn_hit_o = 1'b1;
        rgn_dom_o = tbl_q[i].dom;
      end
    end
  end

  assign tbl_o = tbl_q;

  // a page hit always lies inside a covered region (R4)
  p_hit_in_region_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vpn_hit_o |-> rgn_hit_o);
endmodule

// File: rtl/pc_cfg_check.sv
module pc_cfg_check
  import pc_pkg::*;
#(
  parameter int unsigned ENTRIES = 8,
  localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [IDX_W-1:0]     wr_idx_i,
  input  entry_t               wr_entry_i,
  input  entry_t [ENTRIES-1:0] tbl_i,
  output logic                 cfg_err_o
);
  logic [ENTRIES-1:0] alias_bad, rgn_bad;
  logic               err_q;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    logic peer;
    logic [N_SUB-1:0] both_live;
    assign peer = wr_entry_i.valid && tbl_i[g].valid && (wr_idx_i != IDX_W'(g));
    for (genvar s = 0; s < N_SUB; s++) begin : g_sub
      assign both_live[s] = sp_live(tbl_i[g].perm[2*s +: 2]) &&
                            sp_live(wr_entry_i.perm[2*s +: 2]);
    end
    assign alias_bad[g] = peer && (tbl_i[g].ppn == wr_entry_i.ppn) && |both_live;
    assign rgn_bad[g]   = peer && (tbl_i[g].vpn[VPN_W-1:8] == wr_entry_i.vpn[VPN_W-1:8]) &&
                          (tbl_i[g].dom != wr_entry_i.dom);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= wr_en_i && (|alias_bad || |rgn_bad);
  end

  assign cfg_err_o = err_q;

  p_err_after_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> $past(wr_en_i));
  p_invalid_no_err_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_entry_i.valid) |=> !cfg_err_o);
endmodule

// File: rtl/pc_dom_gate.sv
module pc_dom_gate
  import pc_pkg::*;
(
  input  logic [DCR_W-1:0] dcr_i,
  input  logic [DOM_W-1:0] dom_i,
  output logic             grant_o
);
  logic [N_DOM-1:0] grant_vec;

  for (genvar d = 0; d < N_DOM; d++) begin : g_dom
    assign grant_vec[d] = (dcr_i[2*d +: 2] == DCR_CHK);
  end

  assign grant_o = grant_vec[dom_i];
endmodule

// File: rtl/sp_perm_checker.sv
module sp_perm_checker
  import pc_pkg::*;
#(
  parameter int unsigned ENTRIES = 8,
  localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int unsigned PA_W  = PPN_W + 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [VA_W-1:0]   req_addr_i,
  input  logic              req_write_i,
  input  logic              cfg_we_i,
  input  logic [IDX_W-1:0]  cfg_idx_i,
  input  logic              cfg_valid_i,
  input  logic [VPN_W-1:0]  cfg_vpn_i,
  input  logic [PPN_W-1:0]  cfg_ppn_i,
  input  logic [DOM_W-1:0]  cfg_dom_i,
  input  logic [PERM_W-1:0] cfg_perm_i,
  input  logic              dcr_we_i,
  input  logic [DCR_W-1:0]  dcr_data_i,
  output logic              cfg_err_o,
  output logic              rsp_valid_o,
  output logic [PA_W-1:0]   rsp_paddr_o,
  output logic [1:0]        rsp_fault_o,
  output logic [VA_W-1:0]   rsp_fault_addr_o,
  output logic              rsp_fault_write_o
);
  entry_t               wr_entry;
  entry_t [ENTRIES-1:0] tbl;
  logic [DCR_W-1:0]     dcr_q;
  logic                 vpn_hit, rgn_hit, dom_ok, sp_ok;
  logic [PPN_W-1:0]     hit_ppn;
  logic [PERM_W-1:0]    hit_perm;
  logic [DOM_W-1:0]     rgn_dom;
  logic [1:0]           sp_code;
  fault_e               fault_d;

  logic                 rsp_valid_q, fwrite_q;
  logic [PA_W-1:0]      paddr_q;
  fault_e               fault_q;
  logic [VA_W-1:0]      faddr_q;

  assign wr_entry = '{valid: cfg_valid_i, vpn: cfg_vpn_i, ppn: cfg_ppn_i,
                      dom: cfg_dom_i, perm: cfg_perm_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       dcr_q <= '0;
    else if (dcr_we_i) dcr_q <= dcr_data_i;
  end

  pc_map_table #(.ENTRIES(ENTRIES)) i_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (cfg_we_i),
    .wr_idx_i   (cfg_idx_i),
    .wr_entry_i (wr_entry),
    .lk_addr_i  (req_addr_i),
    .tbl_o      (tbl),
    .vpn_hit_o  (vpn_hit),
    .hit_ppn_o  (hit_ppn),
    .hit_perm_o (hit_perm),
    .rgn_hit_o  (rgn_hit),
    .rgn_dom_o  (rgn_dom)
  );

  pc_cfg_check #(.ENTRIES(ENTRIES)) i_cfg_check (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (cfg_we_i),
    .wr_idx_i   (cfg_idx_i),
    .wr_entry_i (wr_entry),
    .tbl_i      (tbl),
    .cfg_err_o  (cfg_err_o)
  );

  pc_dom_gate i_dom_gate (
    .dcr_i   (dcr_q),
    .dom_i   (rgn_dom),
    .grant_o (dom_ok)
  );

  assign sp_code = hit_perm[2*req_addr_i[11:10] +: 2];
  assign sp_ok   = req_write_i ? (sp_code == SP_RW) : sp_live(sp_code);

  always_comb begin
    if (rgn_hit && !dom_ok) fault_d = FLT_DOMAIN;
    else if (!vpn_hit)      fault_d = FLT_XLATE;
    else if (!sp_ok)        fault_d = FLT_PERM;
    else                    fault_d = FLT_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      paddr_q     <= '0;
      fault_q     <= FLT_NONE;
      faddr_q     <= '0;
      fwrite_q    <= 1'b0;
    end else begin
      rsp_valid_q <= req_valid_i;
      if (req_valid_i) begin
        fault_q  <= fault_d;
        paddr_q  <= (fault_d == FLT_NONE) ? {hit_ppn, req_addr_i[11:0]} : '0;
        faddr_q  <= (fault_d == FLT_NONE) ? '0 : req_addr_i;
        fwrite_q <= (fault_d != FLT_NONE) && req_write_i;
      end
    end
  end

  assign rsp_valid_o       = rsp_valid_q;
  assign rsp_paddr_o       = paddr_q;
  assign rsp_fault_o       = fault_q;
  assign rsp_fault_addr_o  = faddr_q;
  assign rsp_fault_write_o = fwrite_q;

  p_rsp_follows_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  p_rsp_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);
  p_fault_pa_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o != FLT_NONE) |-> (rsp_paddr_o == '0));
  p_ok_clean_report_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o == FLT_NONE) |-> (rsp_fault_addr_o == '0 && !rsp_fault_write_o));
  p_dom_denied_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && rgn_hit && dcr_q[2*rgn_dom +: 2] != DCR_CHK) |=> (rsp_fault_o == FLT_DOMAIN));
  p_write_needs_rw_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_write_i && vpn_hit && sp_code != SP_RW) |=> (rsp_fault_o != FLT_NONE));
endmodule

// File: tb/test_sp_perm_checker.sv
module test_sp_perm_checker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic        cfg_we = 1'b0, cfg_valid = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [19:0] cfg_vpn = '0, cfg_ppn = '0;
  logic [3:0]  cfg_dom = '0;
  logic [7:0]  cfg_perm = '0;
  logic        dcr_we = 1'b0;
  logic [31:0] dcr_data = '0;
  logic        cfg_err, rsp_valid, rsp_fwrite;
  logic [31:0] rsp_paddr, rsp_faddr;
  logic [1:0]  rsp_fault;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  sp_perm_checker i_sp_perm_checker (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_addr_i(req_addr), .req_write_i(req_write),
    .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_valid_i(cfg_valid),
    .cfg_vpn_i(cfg_vpn), .cfg_ppn_i(cfg_ppn), .cfg_dom_i(cfg_dom), .cfg_perm_i(cfg_perm),
    .dcr_we_i(dcr_we), .dcr_data_i(dcr_data),
    .cfg_err_o(cfg_err), .rsp_valid_o(rsp_valid), .rsp_paddr_o(rsp_paddr),
    .rsp_fault_o(rsp_fault), .rsp_fault_addr_o(rsp_faddr), .rsp_fault_write_o(rsp_fwrite)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one request; response checked in the cycle after the sampling edge
  task automatic do_req(input string tag, input logic [31:0] a, input logic w,
                        input logic [1:0] ef, input logic [31:0] epa);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = w;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " valid (R2)"}, 32'(rsp_valid), 32'd1);
    chk({tag, " fault"}, 32'(rsp_fault), 32'(ef));
    chk({tag, " paddr (R8)"}, rsp_paddr, epa);
    chk({tag, " faddr (R8)"}, rsp_faddr, (ef != 0) ? a : 32'd0);
    chk({tag, " fwrite (R8)"}, 32'(rsp_fwrite), (ef != 0) ? 32'(w) : 32'd0);
    @(negedge clk);
    chk({tag, " pulse (R2)"}, 32'(rsp_valid), 32'd0);
  endtask

  task automatic wr_ent(input string tag, input int idx, input logic v, input logic [19:0] vpn,
                        input logic [19:0] ppn, input logic [3:0] dom, input logic [7:0] perm,
                        input logic exp_err);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_valid = v;
    cfg_vpn = vpn; cfg_ppn = ppn; cfg_dom = dom; cfg_perm = perm;
    @(negedge clk);
    cfg_we = 1'b0;
    chk({tag, " cfg_err"}, 32'(cfg_err), 32'(exp_err));
  endtask

  task automatic wr_dcr(input logic [31:0] v);
    @(negedge clk);
    dcr_we = 1'b1; dcr_data = v;
    @(negedge clk);
    dcr_we = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 rsp_valid at reset", 32'(rsp_valid), 32'd0);
    chk("R1 cfg_err at reset", 32'(cfg_err), 32'd0);
    do_req("R1 empty table read", 32'h0010_0000, 1'b0, 2'd2, 32'd0);
  endtask

  // entry0: sp0 RW, sp1 RO, sp2 none, sp3 reserved
  task automatic t_subpage();
    wr_ent("R9 entry0", 0, 1'b1, 20'h00100, 20'h00AB0, 4'd3, 8'h87, 1'b0);
    wr_dcr(32'h0000_0040);
    do_req("R6 read sp0 RW", 32'h0010_0004, 1'b0, 2'd0, 32'h00AB_0004);
    do_req("R6 write sp0 RW", 32'h0010_0004, 1'b1, 2'd0, 32'h00AB_0004);
    do_req("R6 read sp1 RO", 32'h0010_0404, 1'b0, 2'd0, 32'h00AB_0404);
    do_req("R6 write sp1 RO", 32'h0010_0404, 1'b1, 2'd3, 32'd0);
    do_req("R6 read sp2 none", 32'h0010_0808, 1'b0, 2'd3, 32'd0);
    do_req("R6 read sp3 reserved", 32'h0010_0C00, 1'b0, 2'd3, 32'd0);
  endtask

  task automatic t_domain_priority();
    do_req("R5 unmapped page", 32'h0010_5000, 1'b0, 2'd2, 32'd0);
    wr_dcr(32'h0000_0000);
    do_req("R3 field 00 denies", 32'h0010_0004, 1'b0, 2'd1, 32'd0);
    do_req("R7 domain over xlate", 32'h0010_5000, 1'b1, 2'd1, 32'd0);
    wr_dcr(32'h0000_00C0);
    do_req("R3 field 11 denies", 32'h0010_0004, 1'b0, 2'd1, 32'd0);
    wr_dcr(32'h0000_0080);
    do_req("R3 field 10 denies", 32'h0010_0004, 1'b0, 2'd1, 32'd0);
    wr_dcr(32'h0000_0040);
    do_req("R7 perm after domain ok", 32'h0010_0404, 1'b1, 2'd3, 32'd0);
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    dcr_we = 1'b1; dcr_data = 32'h0; req_valid = 1'b1; req_addr = 32'h0010_0004; req_write = 1'b0;
    @(negedge clk);
    dcr_we = 1'b0; req_valid = 1'b0;
    chk("R12 same-cycle dcr write sees old", 32'(rsp_fault), 32'd0);
    do_req("R12 dcr write visible next", 32'h0010_0004, 1'b0, 2'd1, 32'd0);
    wr_dcr(32'h0000_0040);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'd6; cfg_valid = 1'b1; cfg_vpn = 20'h00400;
    cfg_ppn = 20'h00F00; cfg_dom = 4'd3; cfg_perm = 8'h03;
    req_valid = 1'b1; req_addr = 32'h0040_0000; req_write = 1'b0;
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    chk("R12 same-cycle entry write sees old", 32'(rsp_fault), 32'd2);
    do_req("R12 entry write visible next", 32'h0040_0000, 1'b0, 2'd0, 32'h00F0_0000);
  endtask

  task automatic t_region();
    wr_ent("R10 domain clash in region", 1, 1'b1, 20'h00101, 20'h00AB1, 4'd5, 8'h03, 1'b1);
    do_req("R4 region domain from lowest idx", 32'h0010_1000, 1'b0, 2'd0, 32'h00AB_1000);
    wr_ent("R10 region clash cleared", 1, 1'b1, 20'h00101, 20'h00AB1, 4'd3, 8'h03, 1'b0);
  endtask

  task automatic t_alias();
    wr_ent("R9 alias disjoint", 2, 1'b1, 20'h00200, 20'h00AB0, 4'd3, 8'h10, 1'b0);
    wr_ent("R9 alias overlap sp0", 3, 1'b1, 20'h00201, 20'h00AB0, 4'd3, 8'h01, 1'b1);
    wr_ent("R9 invalid write no flag", 3, 1'b0, 20'h00201, 20'h00AB0, 4'd3, 8'h01, 1'b0);
    do_req("R9 alias page read", 32'h0020_0800, 1'b0, 2'd0, 32'h00AB_0800);
    do_req("R9 invalidated entry", 32'h0020_1000, 1'b0, 2'd2, 32'd0);
  endtask

  task automatic t_multi_hit();
    wr_ent("R11 duplicate vpn", 4, 1'b1, 20'h00100, 20'h00CD0, 4'd3, 8'hFF, 1'b0);
    do_req("R11 lowest idx ppn", 32'h0010_0004, 1'b0, 2'd0, 32'h00AB_0004);
    do_req("R11 lowest idx perm", 32'h0010_0404, 1'b1, 2'd3, 32'd0);
  endtask

  task automatic t_other_domain();
    wr_ent("R3 entry dom7", 5, 1'b1, 20'h00300, 20'h00EE0, 4'd7, 8'h03, 1'b0);
    do_req("R3 dom7 denied", 32'h0030_0000, 1'b1, 2'd1, 32'd0);
    wr_dcr(32'h0000_4040);
    do_req("R3 dom7 granted", 32'h0030_0010, 1'b1, 2'd0, 32'h00EE_0010);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_subpage();
    t_domain_priority();
    t_same_cycle();
    t_region();
    t_alias();
    t_multi_hit();
    t_other_domain();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule